// File: doc/BRIEF.md
# Calendar Clock Register File with Byte Memory

A byte-wide static memory whose eight highest addresses form a calendar clock. The year, month, date, day of week, hours, minutes and seconds bytes hold packed BCD, with hours on a 24-hour scale. A control byte sits just under the clock bytes. The clock bytes are ordinary storage cells. A hidden set of calendar counters advances on each one-cycle pulse of `sec_tick`. On that same tick the new counter value is copied into the visible clock bytes, unless one of the two freeze bits in the control byte is set.

Software sets the clock in three steps. It sets the write-freeze bit, writes the clock bytes, then clears the freeze bit. Clearing that bit loads the hidden counters from the bytes as written. To take a coherent multi-byte snapshot, software sets the read-freeze bit. The visible bytes then hold still while the counters keep running.

The port is sampled on the clock with active-low chip, output and write enables. A power-fail input discards every write while the calendar keeps counting. The array size is set by `ADDR_W`; the full-size part uses 19 address lines, and the default is small for simulation.

Top module: `rtc_sram`

## Requirements
- R1: With `ce_n`=0, `we_n`=1 and `oe_n`=0, `data_drive` is 1 and `data_out` shows the byte at `addr` in the same cycle.
- R2: With `ce_n`=1, or `we_n`=0, or `oe_n`=1, `data_drive` is 0, which stands for a high-impedance bus.
- R3: With `ce_n`=0, `we_n`=0 and `pwr_fail`=0, `data_in` is stored at `addr` on the clock edge and reads back from the next cycle on. This applies to every general address below the control byte.
- R4: While `pwr_fail`=1, writes to general memory, the clock bytes and the control byte are all discarded, but ticks still advance the calendar and still refresh the clock bytes.
- R5: Each tick advances seconds 00..59 with carry into minutes 00..59. Minutes carry into hours 00..23. The hours carry advances the date and the day of week, and the day of week wraps from 7 to 1. All values are packed BCD (tens in bits 7:4, units in bits 3:0).
- R6: After date 28, 29, 30 or 31, the date returns to 01 and the month advances. February ends on 29 when the two-digit year is divisible by 4 (including 00) and on 28 otherwise. April, June, September and November end on 30; the other months end on 31. Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R7: Relative to TOP = 2^ADDR_W-1, the address map is: TOP year, TOP-1 month, TOP-2 date, TOP-3 day, TOP-4 hours, TOP-5 minutes, TOP-6 seconds, TOP-7 control. After reset the clock reads 00-01-01, day 1, 00:00:00, and the control byte reads 00.
- R8: With control bits 7 and 6 both 0, a tick makes the clock bytes show the advanced time from the next cycle on.
- R9: With control bit 6 (read-freeze) set, ticks leave the clock bytes unchanged while the counters run. After the bit is cleared, the next tick shows the time including every missed tick.
- R10: With control bit 7 (write-freeze) set, ticks do not refresh the clock bytes. A control write that clears bit 7 loads the counters from the clock bytes. Writing a clock byte while bit 7 is 0 does not load the counters, so the next tick overwrites it.
- R11: Control bits 4:0 hold a calibration value that reads back as written and has no effect on counting.
- R12: A user write to a clock byte in the same cycle as a refreshing tick wins for that byte. The other bytes take the advanced time, and the hidden counters are not changed by the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| data_in | input | 8 | Write data |
| data_out | output | 8 | Read data, valid while data_drive is 1 |
| data_drive | output | 1 | Bus drive enable; 0 means high impedance |
| sec_tick | input | 1 | One-cycle pulse per second |
| pwr_fail | input | 1 | Supply out of tolerance; blocks all writes |

## Verification
The once-per-second refresh of the clock bytes and a user write to one of those bytes can land on the same clock edge. The bench provokes this by raising `sec_tick` in the same cycle as a minutes-byte write and, separately, a seconds-byte write. The written byte must keep the user value while its neighbours carry the advanced time. A following tick must then overwrite it from the untouched counters. A second collision is a freeze-release write arriving on a tick: the load takes priority, and the bench shows this through the time read after the next tick.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int CTL_WFRZ = 7;
  localparam int CTL_RFRZ = 6;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] date;
    logic [7:0] day;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } rtc_time_t;

  localparam rtc_time_t RTC_RST = '{year: 8'h00, month: 8'h01, date: 8'h01,
                                    day: 8'h01, hour: 8'h00, min: 8'h00, sec: 8'h00};

  // packed BCD increment, units carry into tens
  function automatic logic [7:0] bcd_inc(input logic [7:0] b);
    if (b[3:0] == 4'd9) return {b[7:4] + 4'd1, 4'd0};
    return {b[7:4], b[3:0] + 4'd1};
  endfunction

  function automatic logic leap_year(input logic [7:0] y);
    logic [7:0] bin;
    bin = ({4'd0, y[7:4]} * 8'd10) + {4'd0, y[3:0]};
    return bin[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic rtc_time_t rtc_advance(input rtc_time_t t);
    rtc_time_t n;
    n = t;
    if (t.sec != 8'h59) n.sec = bcd_inc(t.sec);
    else begin
      n.sec = 8'h00;
      if (t.min != 8'h59) n.min = bcd_inc(t.min);
      else begin
        n.min = 8'h00;
        if (t.hour != 8'h23) n.hour = bcd_inc(t.hour);
        else begin
          n.hour = 8'h00;
          n.day  = (t.day == 8'h07) ? 8'h01 : bcd_inc(t.day);
          if (t.date != month_last(t.month, t.year)) n.date = bcd_inc(t.date);
          else begin
            n.date = 8'h01;
            if (t.month != 8'h12) n.month = bcd_inc(t.month);
            else begin
              n.month = 8'h01;
              n.year  = (t.year == 8'h99) ? 8'h00 : bcd_inc(t.year);
            end
          end
        end
      end
    end
    return n;
  endfunction

  // byte slot within the clock region: 0 control, 1 sec ... 7 year
  function automatic logic [7:0] time_byte(input rtc_time_t t, input logic [2:0] idx);
    case (idx)
      3'd1:    return t.sec;
      3'd2:    return t.min;
      3'd3:    return t.hour;
      3'd4:    return t.day;
      3'd5:    return t.date;
      3'd6:    return t.month;
      3'd7:    return t.year;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/rtc_counter.sv
module rtc_counter
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t cnt_next,
  output logic [7:0] cnt_sec
);
  rtc_time_t cnt_q;

  assign cnt_next = rtc_advance(cnt_q);
  assign cnt_sec  = cnt_q.sec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= RTC_RST;
    else if (load) cnt_q <= load_val;
    else if (tick) cnt_q <= cnt_next;
  end
endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank
  import rtc_pkg::*;
#(
  parameter int SLOTS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [2:0]            wr_idx,
  input  logic [7:0]            wr_data,
  input  logic                  copy_en,
  input  rtc_time_t             copy_val,
  output logic [SLOTS-1:0][7:0] bank_q
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    localparam logic [2:0] IDX = 3'(g);
    if (g == 0) begin : g_ctl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         bank_q[g] <= 8'h00;
        else if (wr_en && wr_idx == IDX)    bank_q[g] <= wr_data;
      end
    end else begin : g_time
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         bank_q[g] <= time_byte(RTC_RST, IDX);
        else if (wr_en && wr_idx == IDX)    bank_q[g] <= wr_data;
        else if (copy_en)                   bank_q[g] <= time_byte(copy_val, IDX);
      end
    end
  end
endmodule

// File: rtl/rtc_mem.sv
module rtc_mem #(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = (1 << ADDR_W) - 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/rtc_sram.sv
module rtc_sram
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data_in,
  output logic [7:0]        data_out,
  output logic              data_drive,
  input  logic              sec_tick,
  input  logic              pwr_fail
);
  localparam int SLOTS     = 8;
  localparam int MEM_DEPTH = (1 << ADDR_W) - SLOTS;

  logic            clk_region, wr_go, rd_go, reg_wr, mem_wr;
  logic            tick_copy, freeze_release;
  logic [2:0]      reg_idx;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]      mem_rdata, ctl_q, sec_reg, sec_cnt;
  logic [SLOTS-1:0][7:0] bank_q;
  rtc_time_t       bank_time, cnt_next;

  // mode decode
  assign clk_region = &addr[ADDR_W-1:3];
  assign reg_idx    = addr[2:0];
  assign wr_go      = !ce_n && !we_n && !pwr_fail;
  assign rd_go      = !ce_n && we_n;
  assign data_drive = rd_go && !oe_n;
  assign reg_wr     = wr_go && clk_region;
  assign mem_wr     = wr_go && !clk_region;
  assign mem_addr   = clk_region ? '0 : addr;

  // control events
  assign ctl_q          = bank_q[0];
  assign sec_reg        = bank_q[1];
  assign tick_copy      = sec_tick && !ctl_q[CTL_WFRZ] && !ctl_q[CTL_RFRZ];
  assign freeze_release = reg_wr && reg_idx == 3'd0 && ctl_q[CTL_WFRZ] && !data_in[CTL_WFRZ];

  assign bank_time = '{year: bank_q[7], month: bank_q[6], date: bank_q[5], day: bank_q[4],
                       hour: bank_q[3], min: bank_q[2], sec: bank_q[1]};

  rtc_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick), .load(freeze_release),
    .load_val(bank_time), .cnt_next(cnt_next), .cnt_sec(sec_cnt)
  );

  rtc_regbank #(.SLOTS(SLOTS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_idx(reg_idx), .wr_data(data_in),
    .copy_en(tick_copy), .copy_val(cnt_next), .bank_q(bank_q)
  );

  rtc_mem #(.ADDR_W(ADDR_W), .DEPTH(MEM_DEPTH)) u_mem (
    .clk(clk), .we(mem_wr), .addr(mem_addr), .wdata(data_in), .rdata(mem_rdata)
  );

  always_comb begin
    data_out = 8'h00;
    if (data_drive) data_out = clk_region ? bank_q[reg_idx] : mem_rdata;
  end
endmodule

// File: rtl/rtc_sram_chk.sv
module rtc_sram_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       oe_n,
  input logic       we_n,
  input logic       data_drive,
  input logic       reg_wr,
  input logic [2:0] reg_idx,
  input logic [7:0] data_in,
  input logic       pwr_fail,
  input logic       tick_copy,
  input logic       freeze_release,
  input logic [7:0] ctl_q,
  input logic [7:0] sec_reg,
  input logic [7:0] sec_cnt
);
  // R1
  a_r1_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && we_n && !oe_n) |-> data_drive);
  // R2
  a_r2_quiet_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !data_drive);
  // R4
  a_r4_ctl_held_pf: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> $stable(ctl_q));
  // R8
  a_r8_copy_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_copy && !reg_wr) |=> (sec_reg == sec_cnt));
  // R9
  a_r9_rfrz_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[6] && !reg_wr) |=> $stable(sec_reg));
  // R10
  a_r10_release_loads: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_release |=> (sec_cnt == $past(sec_reg)));
  // R12
  a_r12_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx == 3'd1) |=> (sec_reg == $past(data_in)));
endmodule

bind rtc_sram rtc_sram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .data_drive(data_drive), .reg_wr(reg_wr), .reg_idx(reg_idx), .data_in(data_in),
  .pwr_fail(pwr_fail), .tick_copy(tick_copy), .freeze_release(freeze_release),
  .ctl_q(ctl_q), .sec_reg(sec_reg), .sec_cnt(sec_cnt)
);

// File: tb/rtc_sram_tb.sv
module rtc_sram_tb_top;
  localparam int PERIOD = 10;
  localparam int AW     = 8;
  localparam int TOP    = (1 << AW) - 1;
  localparam int A_YEAR = TOP, A_MON = TOP - 1, A_DATE = TOP - 2, A_DAY = TOP - 3;
  localparam int A_HOUR = TOP - 4, A_MIN = TOP - 5, A_SEC = TOP - 6, A_CTL = TOP - 7;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1, sec_tick = 0, pwr_fail = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] data_in = '0, data_out;
  logic data_drive;
  int total = 0, bad = 0;
  int ms, mm, mh, mdw, mdt, mmo, myr;

  always #(PERIOD/2) clk = ~clk;

  rtc_sram #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
    .data_in(data_in), .data_out(data_out), .data_drive(data_drive),
    .sec_tick(sec_tick), .pwr_fail(pwr_fail)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int dim(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_tick();
    ms++;
    if (ms == 60) begin ms = 0; mm++; end
    if (mm == 60) begin mm = 0; mh++; end
    if (mh == 24) begin
      mh = 0; mdw = (mdw == 7) ? 1 : mdw + 1;
      if (mdt == dim(mmo, myr)) begin
        mdt = 1; mmo++;
        if (mmo == 13) begin mmo = 1; myr = (myr + 1) % 100; end
      end else mdt++;
    end
  endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    ce_n = 0; we_n = 0; oe_n = 1; addr = AW'(a); data_in = d;
    @(posedge clk); #1;
    ce_n = 1; we_n = 1;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    ce_n = 0; we_n = 1; oe_n = 0; addr = AW'(a);
    #1 d = data_out;
    ce_n = 1; oe_n = 1;
  endtask

  task automatic rd_chk(input string tag, input int a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1;
    @(posedge clk); #1 sec_tick = 0;
    model_tick();
  endtask

  task automatic chk_all(input string tag);
    rd_chk(tag, A_SEC, bcd(ms));   rd_chk(tag, A_MIN, bcd(mm));
    rd_chk(tag, A_HOUR, bcd(mh));  rd_chk(tag, A_DAY, bcd(mdw));
    rd_chk(tag, A_DATE, bcd(mdt)); rd_chk(tag, A_MON, bcd(mmo));
    rd_chk(tag, A_YEAR, bcd(myr));
  endtask

  // R10 load path: freeze, write bytes, release
  task automatic set_time(input int yr, input int mo, input int dt, input int dw,
                          input int h, input int m, input int s);
    wr(A_CTL, 8'h80);
    wr(A_YEAR, bcd(yr)); wr(A_MON, bcd(mo)); wr(A_DATE, bcd(dt)); wr(A_DAY, bcd(dw));
    wr(A_HOUR, bcd(h));  wr(A_MIN, bcd(m));  wr(A_SEC, bcd(s));
    wr(A_CTL, 8'h00);
    myr = yr; mmo = mo; mdt = dt; mdw = dw; mh = h; mm = m; ms = s;
  endtask

  initial begin
    #(PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    ms = 0; mm = 0; mh = 0; mdw = 1; mdt = 1; mmo = 1; myr = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R7 reset state and layout
    chk("R2 reset", {7'd0, data_drive}, 8'h00);
    rd_chk("R7 ctl", A_CTL, 8'h00);
    chk_all("R7 reset");

    // R1 / R2 strobe combinations
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      ce_n = c[2]; oe_n = c[1]; we_n = c[0]; addr = AW'(A_SEC); pwr_fail = 1;
      #1;
      chk((c == 1) ? "R1 drive" : "R2 drive", {7'd0, data_drive}, (c == 1) ? 8'h01 : 8'h00);
      if (c == 1) chk("R1 data", data_out, 8'h00);
      ce_n = 1; oe_n = 1; we_n = 1; pwr_fail = 0;
    end

    // R3 general memory sweep
    for (int a = 0; a < A_CTL; a++) wr(a, 8'((a * 7 + 3) & 8'hff));
    for (int a = 0; a < A_CTL; a++) rd_chk("R3 mem", a, 8'((a * 7 + 3) & 8'hff));

    // R11 calibration stored, counting unaffected
    wr(A_CTL, 8'h15);
    rd_chk("R11 cal", A_CTL, 8'h15);
    tick();
    rd_chk("R11 count", A_SEC, bcd(ms));
    wr(A_CTL, 8'h00);

    // R5 / R8 sweep through more than an hour
    set_time(10, 5, 5, 2, 22, 59, 50);
    chk_all("R10 set");
    for (int i = 0; i < 3700; i++) begin
      tick();
      rd_chk("R8 sec", A_SEC, bcd(ms));
      rd_chk("R5 min", A_MIN, bcd(mm));
      rd_chk("R5 hour", A_HOUR, bcd(mh));
    end
    chk_all("R5 after sweep");

    // R6 month ends across leap and non-leap years
    for (int yi = 0; yi < 5; yi++) begin
      int yr;
      yr = (yi == 4) ? 99 : yi;
      for (int mo = 1; mo <= 12; mo++) begin
        set_time(yr, mo, dim(mo, yr), 7, 23, 59, 59);
        tick();
        chk_all("R6 month end");
      end
      set_time(yr, 2, 28, 3, 23, 59, 59);
      tick();
      chk_all("R6 feb 28");
    end

    // R10 write without freeze is overwritten by next tick
    set_time(20, 3, 14, 4, 12, 0, 10);
    wr(A_SEC, 8'h30);
    rd_chk("R10 plain write", A_SEC, 8'h30);
    tick();
    rd_chk("R10 no load", A_SEC, bcd(ms));

    // R9 read freeze
    wr(A_CTL, 8'h40);
    rd(A_SEC, v);
    chk("R9 frozen start", v, bcd(ms));
    tick(); tick(); tick();
    rd_chk("R9 frozen", A_SEC, v);
    wr(A_CTL, 8'h00);
    tick();
    chk_all("R9 resumed");

    // R10 write freeze holds bytes
    wr(A_CTL, 8'h80);
    rd(A_MIN, v);
    tick(); tick();
    rd_chk("R10 frozen", A_MIN, v);
    rd_chk("R10 frozen sec", A_SEC, bcd(ms - 2));
    wr(A_CTL, 8'h00);
    ms = ms - 2;        // counters reloaded from the held bytes
    tick();
    chk_all("R10 reload");

    // R4 power fail blocks writes, clock keeps counting
    @(negedge clk); pwr_fail = 1;
    wr(5, 8'hA5); wr(A_CTL, 8'h80); wr(A_SEC, 8'h00);
    tick(); tick();
    @(negedge clk); pwr_fail = 0;
    rd_chk("R4 mem", 5, 8'((5 * 7 + 3) & 8'hff));
    rd_chk("R4 ctl", A_CTL, 8'h00);
    chk_all("R4 counting");

    // R12 user write collides with refreshing tick
    @(negedge clk);
    sec_tick = 1; ce_n = 0; we_n = 0; addr = AW'(A_MIN); data_in = 8'h45;
    @(posedge clk); #1 sec_tick = 0; ce_n = 1; we_n = 1;
    model_tick();
    rd_chk("R12 written", A_MIN, 8'h45);
    rd_chk("R12 others", A_SEC, bcd(ms));
    @(negedge clk);
    sec_tick = 1; ce_n = 0; we_n = 0; addr = AW'(A_SEC); data_in = 8'h07;
    @(posedge clk); #1 sec_tick = 0; ce_n = 1; we_n = 1;
    model_tick();
    rd_chk("R12 sec written", A_SEC, 8'h07);
    tick();
    chk_all("R12 counters untouched");

    // R10 release on the same edge as a tick: load wins
    wr(A_CTL, 8'h80);
    wr(A_SEC, 8'h20);
    @(negedge clk);
    sec_tick = 1; ce_n = 0; we_n = 0; addr = AW'(A_CTL); data_in = 8'h00;
    @(posedge clk); #1 sec_tick = 0; ce_n = 1; we_n = 1;
    ms = 20;
    tick();
    chk_all("R10 release on tick");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule